// File: doc/BRIEF.md
# Private-Cache Load-Linked / Store-Conditional Reservation Tracker

This block sits inside a private first-level cache controller, between the processor and the memory side. It keeps exactly one reservation. A reservation is an address register with a valid flag and a copy of the word that the reserving load-linked (LL) returned. The tracker serves processor LL and store-conditional (SC) requests. It forwards a request to memory only when the memory side has to take part. It also watches the invalidate and update notices that memory sends back, and clears the reservation when a notice names the reserved line.

A repeated LL to the reserved address is answered from the held copy, with no memory traffic. An SC whose address does not match a live reservation fails at once and never reaches memory. A matching SC goes to memory, and memory's verdict is passed back to the processor. The cache data array and its replacement policy are not part of this block; every read that does leave the block is answered by the memory port.

The processor request, processor response and memory request are valid/ready streams. A stream's payload must stay stable while valid is high and ready is low. A transfer happens on a clock edge where both are high. The memory response and the notice input are single-cycle pulses that are always accepted. Only one processor request is in flight at a time: `cpu_req_ready` stays low from the edge that accepts a request until the edge that hands over its response.

Top module: `llsc_resv_tracker`

## Requirements
- R1: After reset no reservation is held, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_req_valid` are 0. An SC issued first fails locally.
- R2: An LL whose full address equals the stored address while the flag is set is answered with the word returned by the LL that made the reservation. It issues no memory request.
- R3: Any other LL issues a memory request with op 0 (LL) and the same address. It sets the flag, replaces the stored address (dropping any earlier reservation), and returns the memory response data.
- R4: An SC to the stored address while the flag is set is forwarded with op 1 (SC), the same address and the same write data. The processor response carries memory's bit 0 in bit 0 (1 = success) and zeros in every other bit.
- R5: An SC with the flag clear, or with an address that differs in any bit from the stored one, returns 0, issues no memory request, and clears the flag.
- R6: A notice whose line (address bits above the low LINE_OFFS_W bits) equals the stored address's line clears the flag. A notice for any other line leaves it unchanged.
- R7: After a forwarded SC returns, the flag is clear whether it succeeded or failed.
- R8: `cpu_req_ready` is 0 while a request is in flight. `cpu_rsp_valid`/`cpu_rsp_data` hold until `cpu_rsp_ready`. `mem_req_valid` and its payload hold until `mem_req_ready`.
- R9: A notice for the reserved line in the same cycle that an LL to that address is accepted is applied first, so the LL goes to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Tracker can accept a request |
| cpu_req_op | input | 1 | 0 = LL, 1 = SC |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | SC write data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_data | output | DATA_W | LL data or SC result in bit 0 |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_op | output | 1 | 0 = LL, 1 = SC |
| mem_req_addr | output | ADDR_W | Forwarded address |
| mem_req_wdata | output | DATA_W | Forwarded SC data |
| mem_rsp_valid | input | 1 | Memory response pulse |
| mem_rsp_data | input | DATA_W | LL data, or SC verdict in bit 0 |
| ntf_valid | input | 1 | Invalidate/update notice pulse |
| ntf_line | input | ADDR_W-LINE_OFFS_W | Line address of the notice |

## Verification
A reservation flag stuck high shows up at the next SC to the last address: the SC leaves the block on the memory port when it should fail locally. A flag stuck low turns the next repeated LL into memory traffic. Either fault is visible within one request of its cause. A wrong stored address or data copy shows in the data of a locally served LL in the same transaction. A notice compared on the wrong bits shows up, on the LL that follows, as a missing or unexpected memory request.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic {OP_LL = 1'b0, OP_SC = 1'b1} llsc_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_MWAIT, ST_RSP} ctl_st_e;
endpackage

// File: rtl/llsc_resv_store.sv
module llsc_resv_store #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_OFFS_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ntf_valid,
  input  logic [ADDR_W-LINE_OFFS_W-1:0] ntf_line,
  input  logic [ADDR_W-1:0]         q_addr,
  input  logic                      set_en,
  input  logic                      clr_en,
  input  logic                      dat_en,
  input  logic [DATA_W-1:0]         dat_in,
  output logic                      flag_q,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [DATA_W-1:0]         dat_q,
  output logic                      q_hit
);
  localparam int LINE_W = ADDR_W - LINE_OFFS_W;

  logic [LINE_W-1:0] line_q;
  logic              ntf_kill;

  assign line_q   = addr_q[ADDR_W-1:LINE_OFFS_W];
  assign ntf_kill = ntf_valid && (ntf_line == line_q);
  // notice is applied before the lookup of the same cycle
  assign q_hit    = flag_q && !ntf_kill && (q_addr == addr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      dat_q  <= '0;
    end else begin
      if (set_en) begin
        flag_q <= 1'b1;
        addr_q <= q_addr;
      end else if (clr_en || ntf_kill) begin
        flag_q <= 1'b0;
      end
      if (dat_en) dat_q <= dat_in;
    end
  end
endmodule

// File: rtl/llsc_ctl_fsm.sv
module llsc_ctl_fsm
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_op,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              q_hit,
  input  logic [DATA_W-1:0] dat_q,
  output logic              set_en,
  output logic              clr_en,
  output logic              dat_en
);
  ctl_st_e           st_q;
  llsc_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rsp_q;
  llsc_op_e          in_op;
  logic              accept;
  logic              rsp_in;

  assign in_op  = llsc_op_e'(cpu_req_op);
  assign accept = (st_q == ST_IDLE) && cpu_req_valid;
  assign rsp_in = (st_q == ST_MWAIT) && mem_rsp_valid;

  assign set_en = accept && (in_op == OP_LL) && !q_hit;
  assign clr_en = (accept && (in_op == OP_SC) && !q_hit) ||
                  (rsp_in && (op_q == OP_SC));
  assign dat_en = rsp_in && (op_q == OP_LL);

  assign cpu_req_ready = (st_q == ST_IDLE);
  assign cpu_rsp_valid = (st_q == ST_RSP);
  assign cpu_rsp_data  = rsp_q;
  assign mem_req_valid = (st_q == ST_MREQ);
  assign mem_req_op    = op_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_LL;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          op_q    <= in_op;
          addr_q  <= cpu_req_addr;
          wdata_q <= cpu_req_wdata;
          if (q_hit && in_op == OP_LL) begin
            rsp_q <= dat_q;
            st_q  <= ST_RSP;
          end else if (in_op == OP_LL || q_hit) begin
            st_q  <= ST_MREQ;
          end else begin
            rsp_q <= '0;
            st_q  <= ST_RSP;
          end
        end
        ST_MREQ:  if (mem_req_ready) st_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          rsp_q <= (op_q == OP_LL) ? mem_rsp_data : DATA_W'(mem_rsp_data[0]);
          st_q  <= ST_RSP;
        end
        ST_RSP:   if (cpu_rsp_ready) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_OFFS_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req_valid,
  output logic                          cpu_req_ready,
  input  logic                          cpu_req_op,
  input  logic [ADDR_W-1:0]             cpu_req_addr,
  input  logic [DATA_W-1:0]             cpu_req_wdata,
  output logic                          cpu_rsp_valid,
  input  logic                          cpu_rsp_ready,
  output logic [DATA_W-1:0]             cpu_rsp_data,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic                          mem_req_op,
  output logic [ADDR_W-1:0]             mem_req_addr,
  output logic [DATA_W-1:0]             mem_req_wdata,
  input  logic                          mem_rsp_valid,
  input  logic [DATA_W-1:0]             mem_rsp_data,
  input  logic                          ntf_valid,
  input  logic [ADDR_W-LINE_OFFS_W-1:0] ntf_line
);
  logic              set_en, clr_en, dat_en, q_hit, resv_flag;
  logic [ADDR_W-1:0] resv_addr;
  logic [DATA_W-1:0] resv_dat;

  llsc_resv_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFFS_W(LINE_OFFS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_line(ntf_line),
    .q_addr(cpu_req_addr), .set_en(set_en), .clr_en(clr_en), .dat_en(dat_en),
    .dat_in(mem_rsp_data), .flag_q(resv_flag), .addr_q(resv_addr),
    .dat_q(resv_dat), .q_hit(q_hit)
  );

  llsc_ctl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_op(cpu_req_op), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_data(cpu_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_op(mem_req_op),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .q_hit(q_hit), .dat_q(resv_dat), .set_en(set_en), .clr_en(clr_en), .dat_en(dat_en)
  );
endmodule

// File: rtl/llsc_resv_tracker_chk.sv
module llsc_resv_tracker_chk #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_OFFS_W = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cpu_req_valid,
  input logic                          cpu_req_ready,
  input logic                          cpu_req_op,
  input logic                          cpu_rsp_valid,
  input logic                          cpu_rsp_ready,
  input logic [DATA_W-1:0]             cpu_rsp_data,
  input logic                          mem_req_valid,
  input logic                          mem_req_ready,
  input logic                          mem_req_op,
  input logic [ADDR_W-1:0]             mem_req_addr,
  input logic                          mem_rsp_valid,
  input logic                          ntf_valid,
  input logic [ADDR_W-LINE_OFFS_W-1:0] ntf_line,
  input logic                          resv_flag,
  input logic [ADDR_W-1:0]             resv_addr
);
  logic cur_op;
  logic acc_ll;
  always_ff @(posedge clk) begin
    if (!rst_n) cur_op <= 1'b0;
    else if (cpu_req_valid && cpu_req_ready) cur_op <= cpu_req_op;
  end
  assign acc_ll = cpu_req_valid && cpu_req_ready && !cpu_req_op;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_data)); // R8
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_op)); // R8
  AST_BUSY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready); // R8
  AST_BUSY_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready); // R8
  AST_SC_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && cur_op |-> cpu_rsp_data[DATA_W-1:1] == '0); // R4
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && cur_op && !cpu_req_ready && !mem_req_valid |=> !resv_flag); // R7
  AST_NTF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && resv_flag && ntf_line == resv_addr[ADDR_W-1:LINE_OFFS_W] && !acc_ll |=> !resv_flag); // R6
endmodule

bind llsc_resv_tracker llsc_resv_tracker_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFFS_W(LINE_OFFS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_op(cpu_req_op), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
  .cpu_rsp_data(cpu_rsp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .ntf_valid(ntf_valid), .ntf_line(ntf_line), .resv_flag(resv_flag), .resv_addr(resv_addr)
);

// File: tb/sim_llsc_resv_tracker.sv
`timescale 1ns/1ps
module sim_llsc_resv_tracker;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cpu_req_valid = 0, cpu_req_op = 0, cpu_rsp_ready = 1, mem_req_ready = 1;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic ntf_valid = 0;
  logic [AW-LO-1:0] ntf_line = '0;
  logic mem_rsp_valid = 0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [DW-1:0] mem_val = '0;
  logic cpu_req_ready, cpu_rsp_valid, mem_req_valid, mem_req_op;
  logic [DW-1:0] cpu_rsp_data, mem_req_wdata;
  logic [AW-1:0] mem_req_addr;

  llsc_resv_tracker #(.ADDR_W(AW), .DATA_W(DW), .LINE_OFFS_W(LO)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_op(cpu_req_op), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_data(cpu_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_op(mem_req_op),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ntf_valid(ntf_valid), .ntf_line(ntf_line)
  );

  // memory model: answers one cycle after each accepted request
  int unsigned mcnt = 0;
  logic m_op;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd;
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem_val;
    if (mem_req_valid && mem_req_ready) begin
      mcnt   <= mcnt + 1;
      m_op   <= mem_req_op;
      m_addr <= mem_req_addr;
      m_wd   <= mem_req_wdata;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // issue one request; returns response data and number of memory requests
  task automatic run_req(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic ntf, output logic [DW-1:0] rd, output int nm);
    int unsigned m0;
    int t;
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    m0 = mcnt;
    cpu_req_valid = 1; cpu_req_op = op; cpu_req_addr = a; cpu_req_wdata = wd;
    ntf_valid = ntf; ntf_line = a[AW-1:LO];
    @(negedge clk);
    cpu_req_valid = 0; ntf_valid = 0;
    t = 0;
    while (!cpu_rsp_valid && t < 50) begin @(negedge clk); t++; end
    rd = cpu_rsp_data;
    nm = int'(mcnt - m0);
    @(negedge clk);
  endtask

  task automatic notice(input logic [AW-LO-1:0] ln);
    @(negedge clk);
    ntf_valid = 1; ntf_line = ln;
    @(negedge clk);
    ntf_valid = 0;
  endtask

  typedef struct packed {
    logic          op;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          ntf;
    logic [DW-1:0] mval;
    logic          xmem;
    logic [DW-1:0] xdat;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{1'b0, 32'h100, 32'h0, 1'b0, 32'h0,   1'b1, 32'h0},   // R3 first LL
    '{1'b0, 32'h100, 32'h0, 1'b0, 32'hEE,  1'b0, 32'h0},   // R2 local LL
    '{1'b1, 32'h100, 32'h1, 1'b0, 32'h1,   1'b1, 32'h1},   // R4 SC success
    '{1'b1, 32'h100, 32'h1, 1'b0, 32'h1,   1'b0, 32'h0},   // R7 flag gone
    '{1'b0, 32'h100, 32'h0, 1'b0, 32'h55,  1'b1, 32'h55},  // R3 re-reserve
    '{1'b1, 32'h104, 32'h2, 1'b0, 32'h1,   1'b0, 32'h0},   // R5 addr differs
    '{1'b1, 32'h100, 32'h2, 1'b0, 32'h1,   1'b0, 32'h0},   // R5 cleared by fail
    '{1'b0, 32'h200, 32'h0, 1'b0, 32'h77,  1'b1, 32'h77},  // R3
    '{1'b0, 32'h200, 32'h0, 1'b1, 32'h78,  1'b1, 32'h78},  // R9 same-cycle notice
    '{1'b1, 32'h200, 32'h3, 1'b0, 32'hFFFFFFFE, 1'b1, 32'h0}, // R4 SC fail bit0 only
    '{1'b0, 32'h300, 32'h0, 1'b0, 32'h9,   1'b1, 32'h9},   // R3
    '{1'b0, 32'h340, 32'h0, 1'b0, 32'hA,   1'b1, 32'hA},   // R3 replaces
    '{1'b1, 32'h300, 32'h4, 1'b0, 32'h1,   1'b0, 32'h0}    // R3 old reservation lost
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    int nm;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req_ready", DW'(cpu_req_ready), 1);
    chk("R1 rsp_valid", DW'(cpu_rsp_valid), 0);
    chk("R1 mem_req_valid", DW'(mem_req_valid), 0);
    run_req(1'b1, 32'h0, 32'h5, 1'b0, rd, nm);
    chk("R1 SC after reset result", rd, 0);
    chk("R1 SC after reset mem", DW'(nm), 0);

    for (int i = 0; i < NV; i++) begin
      mem_val = VT[i].mval;
      run_req(VT[i].op, VT[i].addr, VT[i].wd, VT[i].ntf, rd, nm);
      chk($sformatf("R2/R3/R4/R5 vec%0d data", i), rd, VT[i].xdat);
      chk($sformatf("R2/R5 vec%0d mem count", i), DW'(nm), DW'(VT[i].xmem));
      if (VT[i].xmem) begin
        chk($sformatf("R3/R4 vec%0d mem op", i), DW'(m_op), DW'(VT[i].op));
        chk($sformatf("R3/R4 vec%0d mem addr", i), m_addr, VT[i].addr);
        if (VT[i].op) chk($sformatf("R4 vec%0d mem wdata", i), m_wd, VT[i].wd);
      end
    end

    // R6: notice on the reserved line clears it
    mem_val = 32'h5;
    run_req(1'b0, 32'h400, 32'h0, 1'b0, rd, nm);
    notice(28'h40);
    mem_val = 32'h6;
    run_req(1'b0, 32'h400, 32'h0, 1'b0, rd, nm);
    chk("R6 matching notice forces memory LL", DW'(nm), 1);
    chk("R6 LL data after notice", rd, 32'h6);
    // R6: notice on another line leaves it
    notice(28'h41);
    run_req(1'b0, 32'h400, 32'h0, 1'b0, rd, nm);
    chk("R6 other-line notice ignored", DW'(nm), 0);
    chk("R6 local LL data", rd, 32'h6);

    // R8: processor response back-pressure
    cpu_rsp_ready = 0;
    mem_val = 32'h66;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_op = 0; cpu_req_addr = 32'h600;
    @(negedge clk);
    cpu_req_valid = 0;
    for (int t = 0; t < 50 && !cpu_rsp_valid; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8 rsp held", DW'(cpu_rsp_valid), 1);
    chk("R8 rsp data held", cpu_rsp_data, 32'h66);
    chk("R8 busy while rsp pending", DW'(cpu_req_ready), 0);
    cpu_rsp_ready = 1;
    @(negedge clk);
    chk("R8 idle after handshake", DW'(cpu_req_ready), 1);

    // R8: memory request back-pressure
    mem_req_ready = 0;
    mem_val = 32'h70;
    cpu_req_valid = 1; cpu_req_op = 0; cpu_req_addr = 32'h700;
    @(negedge clk);
    cpu_req_valid = 0;
    repeat (3) @(negedge clk);
    chk("R8 mem req held", DW'(mem_req_valid), 1);
    chk("R8 mem addr held", mem_req_addr, 32'h700);
    chk("R8 busy while mem pending", DW'(cpu_req_ready), 0);
    mem_req_ready = 1;
    for (int t = 0; t < 50 && !cpu_rsp_valid; t++) @(negedge clk);
    chk("R8 data after mem stall", cpu_rsp_data, 32'h70);
    @(negedge clk);

    finish_run();
  end
endmodule